// File: doc/BRIEF.md
# RTC Sub-Second Shift Adjuster

This block is the timekeeping front end of a real-time clock. A sub-second prescaler counts down by one on every prescaler clock enable. When it passes zero it reloads from a programmable reload value, and a seconds counter advances by one. One second therefore lasts `reload + 1` prescaler steps.

Software can correct the time by a fraction of a second through a small write port. The written shift value is added to the down-counting prescaler, which holds the clock back by `shift / (reload + 1)` s. If the add-one-second bit is written in the same access, the seconds counter is also bumped in the same step. The net effect is then an advance of `1 - shift / (reload + 1)` s. A pending flag interlocks the port until the correction has been applied, which happens on the next prescaler enable. Shadow copies of the counters are refreshed two clocks after every prescaler step. A synchronised flag tells software when those copies hold time that includes the last correction.

Top module: `rtc_shift_adj`

## Requirements
- R1: After reset the prescaler holds `reload`, the seconds counter, both shadow copies and the synchronised flag are 0, and no shift is pending.
- R2: On a clock with `ps_en` high and no shift pending, the prescaler decrements by one. At 0 it instead reloads `reload` and the seconds counter increments by one, wrapping modulo 2^SEC_W.
- R3: The shift read-back port `shift_rdata` always reads 0.
- R4: A write (`wr_en` high) while `shift_pending` is low is accepted. It sets `shift_pending` and clears `sync_ok` at that clock edge.
- R5: A write while `shift_pending` is high is ignored: the stored shift value and add bit are unchanged.
- R6: At the first `ps_en` clock after acceptance, the stored shift is added to the prescaler, the normal step of R2 is applied to the sum, and `shift_pending` clears at that same edge. The net time moves back by `shift` prescaler steps. Software must keep `shift <= reload`.
- R7: If prescaler + shift exceeds `reload`, the prescaler takes the excess minus one and the seconds counter drops by one. No underflow is lost or invented.
- R8: If the add bit was stored, the seconds counter is increased by one at the same edge that the shift is applied.
- R9: At the second clock edge after a `ps_en` clock, `shadow_sec` and `shadow_sub` load the live seconds and prescaler values held just before that edge.
- R10: `sync_ok` sets when a shadow copy (R9) happens while no shift is pending. An accepted write at the same edge wins and keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps_en | input | 1 | Prescaler clock enable, one step per high cycle |
| reload | input | PS_W | Prescaler reload value |
| wr_en | input | 1 | Shift register write strobe |
| wr_shift | input | PS_W | Shift value written |
| wr_add1s | input | 1 | Add-one-second bit written |
| shift_rdata | output | PS_W+1 | Read-back of the write-only shift register (always zero) |
| shift_pending | output | 1 | Correction accepted but not yet applied |
| sync_ok | output | 1 | Shadow copies hold corrected time |
| sec_cnt | output | SEC_W | Live seconds counter |
| sub_cnt | output | PS_W | Live sub-second prescaler |
| shadow_sec | output | SEC_W | Shadow copy of seconds |
| shadow_sub | output | PS_W | Shadow copy of prescaler |

## Verification
The counters, `shift_pending` and `sync_ok` change one clock after the edge that samples `ps_en` or `wr_en`. The shadow copies lag a prescaler step by two clocks. The bench drives inputs and samples every output on the falling edge. Its model advances exactly one edge per call, and the shadow model keeps a two-stage delay of the enable, so every comparison lands on the cycle in which the result is due. The model tracks time as one linear step count, which gives expected values for seconds and prescaler independent of the carry logic.

// File: rtl/rtc_shift_pkg.sv
package rtc_shift_pkg;
  localparam int RTC_PS_W  = 15;
  localparam int RTC_SEC_W = 16;

  // Internal counter events, brought out for the checker.
  typedef struct packed {
    logic wrap;   // shift sum crossed a second boundary
    logic uf;     // prescaler passed zero
  } sec_evt_t;
endpackage

// File: rtl/rtc_shift_ctl.sv
module rtc_shift_ctl #(
  parameter int PS_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ps_en,
  input  logic            wr_en,
  input  logic [PS_W-1:0] wr_shift,
  input  logic            wr_add1s,
  output logic            pending,
  output logic            accept,
  output logic            apply,
  output logic [PS_W-1:0] shift_q,
  output logic            add1s_q
);
  assign accept = wr_en && !pending;
  assign apply  = ps_en && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      shift_q <= '0;
      add1s_q <= 1'b0;
    end else if (accept) begin
      pending <= 1'b1;
      shift_q <= wr_shift;
      add1s_q <= wr_add1s;
    end else if (apply) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_shift_pkg::*;
#(
  parameter int PS_W  = 15,
  parameter int SEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ps_en,
  input  logic [PS_W-1:0]  reload,
  input  logic             apply,
  input  logic [PS_W-1:0]  shift_val,
  input  logic             add1s,
  output logic [PS_W-1:0]  sub_cnt,
  output logic [SEC_W-1:0] sec_cnt,
  output sec_evt_t         evt
);
  localparam int SW = PS_W + 1;

  // Returns {wrap, value}: sub + shift folded back into 0..reload.
  function automatic logic [SW-1:0] add_fold(input logic [PS_W-1:0] s,
                                             input logic [PS_W-1:0] d,
                                             input logic [PS_W-1:0] r);
    logic [SW-1:0] sum, lim, diff;
    sum  = {1'b0, s} + {1'b0, d};
    lim  = {1'b0, r} + SW'(1);
    diff = sum - lim;
    if (sum > {1'b0, r}) return {1'b1, diff[PS_W-1:0]};
    return {1'b0, sum[PS_W-1:0]};
  endfunction

  logic [SW-1:0]    adj;
  logic [PS_W-1:0]  mid;
  logic [PS_W-1:0]  sub_nx;
  logic [SEC_W-1:0] sec_nx;
  logic             plus1;

  always_comb begin
    adj      = apply ? add_fold(sub_cnt, shift_val, reload) : {1'b0, sub_cnt};
    mid      = adj[PS_W-1:0];
    evt.wrap = adj[PS_W];
    evt.uf   = (mid == '0);
    plus1    = apply && add1s;
    sub_nx   = evt.uf ? reload : mid - PS_W'(1);
    sec_nx   = sec_cnt + SEC_W'(plus1) - SEC_W'(evt.wrap) + SEC_W'(evt.uf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_cnt <= reload;
      sec_cnt <= '0;
    end else if (ps_en) begin
      sub_cnt <= sub_nx;
      sec_cnt <= sec_nx;
    end
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int PS_W  = 15,
  parameter int SEC_W = 16,
  parameter int LAG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ps_en,
  input  logic             accept,
  input  logic             pending,
  input  logic [PS_W-1:0]  sub_cnt,
  input  logic [SEC_W-1:0] sec_cnt,
  output logic             copy_evt,
  output logic [PS_W-1:0]  shadow_sub,
  output logic [SEC_W-1:0] shadow_sec,
  output logic             sync_ok
);
  logic [LAG-1:0] dly;

  always_ff @(posedge clk) begin
    if (!rst_n) dly <= '0;
    else        dly <= {dly[LAG-2:0], ps_en};
  end
  assign copy_evt = dly[LAG-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_sub <= '0;
      shadow_sec <= '0;
      sync_ok    <= 1'b0;
    end else begin
      if (copy_evt) begin
        shadow_sub <= sub_cnt;
        shadow_sec <= sec_cnt;
      end
      if (accept)                   sync_ok <= 1'b0;
      else if (copy_evt && !pending) sync_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_shift_adj.sv
module rtc_shift_adj
  import rtc_shift_pkg::*;
#(
  parameter int PS_W  = RTC_PS_W,
  parameter int SEC_W = RTC_SEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ps_en,
  input  logic [PS_W-1:0]  reload,
  input  logic             wr_en,
  input  logic [PS_W-1:0]  wr_shift,
  input  logic             wr_add1s,
  output logic [PS_W:0]    shift_rdata,
  output logic             shift_pending,
  output logic             sync_ok,
  output logic [SEC_W-1:0] sec_cnt,
  output logic [PS_W-1:0]  sub_cnt,
  output logic [SEC_W-1:0] shadow_sec,
  output logic [PS_W-1:0]  shadow_sub
);
  logic            accept;
  logic            apply;
  logic            copy_evt;
  logic [PS_W-1:0] shift_q;
  logic            add1s_q;
  sec_evt_t        evt;

  // Shift fields are write-only.
  assign shift_rdata = '0;

  rtc_shift_ctl #(.PS_W(PS_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ps_en(ps_en),
    .wr_en(wr_en), .wr_shift(wr_shift), .wr_add1s(wr_add1s),
    .pending(shift_pending), .accept(accept), .apply(apply),
    .shift_q(shift_q), .add1s_q(add1s_q)
  );

  rtc_prescaler #(.PS_W(PS_W), .SEC_W(SEC_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .reload(reload),
    .apply(apply), .shift_val(shift_q), .add1s(add1s_q),
    .sub_cnt(sub_cnt), .sec_cnt(sec_cnt), .evt(evt)
  );

  rtc_shadow #(.PS_W(PS_W), .SEC_W(SEC_W), .LAG(2)) u_sh (
    .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .accept(accept),
    .pending(shift_pending), .sub_cnt(sub_cnt), .sec_cnt(sec_cnt),
    .copy_evt(copy_evt), .shadow_sub(shadow_sub),
    .shadow_sec(shadow_sec), .sync_ok(sync_ok)
  );
endmodule

// File: rtl/rtc_shift_adj_chk.sv
module rtc_shift_adj_chk #(
  parameter int PS_W  = 15,
  parameter int SEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ps_en,
  input logic [PS_W-1:0]  reload,
  input logic             wr_en,
  input logic             shift_pending,
  input logic             sync_ok,
  input logic             copy_evt,
  input logic [SEC_W-1:0] sec_cnt,
  input logic [PS_W-1:0]  sub_cnt,
  input logic [SEC_W-1:0] shadow_sec,
  input logic [PS_W-1:0]  shadow_sub
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_en && !shift_pending && sub_cnt != '0)
      |=> (sub_cnt == $past(sub_cnt) - PS_W'(1)) && $stable(sec_cnt));

  p_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_en && !shift_pending && sub_cnt == '0)
      |=> (sub_cnt == $past(reload)) && (sec_cnt == $past(sec_cnt) + SEC_W'(1)));

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !shift_pending) |=> (shift_pending && !sync_ok));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pending && !ps_en) |=> shift_pending);

  p_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pending && ps_en) |=> !shift_pending);

  p_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> (shadow_sec == $past(sec_cnt)) && (shadow_sub == $past(sub_cnt)));

  p_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_evt && !shift_pending && !wr_en) |=> sync_ok);
endmodule

bind rtc_shift_adj rtc_shift_adj_chk #(.PS_W(PS_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .reload(reload), .wr_en(wr_en),
  .shift_pending(shift_pending), .sync_ok(sync_ok), .copy_evt(copy_evt),
  .sec_cnt(sec_cnt), .sub_cnt(sub_cnt),
  .shadow_sec(shadow_sec), .shadow_sub(shadow_sub)
);

// File: tb/rtc_shift_adj_test.sv
`timescale 1ns/1ps
module rtc_shift_adj_test;
  localparam int PS_W  = 15;
  localparam int SEC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ps_en;
  logic [PS_W-1:0]  reload;
  logic             wr_en;
  logic [PS_W-1:0]  wr_shift;
  logic             wr_add1s;
  logic [PS_W:0]    shift_rdata;
  logic             shift_pending, sync_ok;
  logic [SEC_W-1:0] sec_cnt, shadow_sec;
  logic [PS_W-1:0]  sub_cnt, shadow_sub;

  rtc_shift_adj #(.PS_W(PS_W), .SEC_W(SEC_W)) uut (
    .clk(clk), .rst_n(rst_n), .ps_en(ps_en), .reload(reload),
    .wr_en(wr_en), .wr_shift(wr_shift), .wr_add1s(wr_add1s),
    .shift_rdata(shift_rdata), .shift_pending(shift_pending), .sync_ok(sync_ok),
    .sec_cnt(sec_cnt), .sub_cnt(sub_cnt),
    .shadow_sec(shadow_sec), .shadow_sub(shadow_sub)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Model: time as one linear count of prescaler steps.
  longint R;
  longint T;
  bit     m_pend, m_a1, m_sync, d1, d2;
  longint m_sh;
  longint m_shsec, m_shsub;

  function automatic longint sec_of(longint t, longint r);
    longint off = (r + 1) * 65536;
    return ((t + off) / (r + 1)) % 65536;
  endfunction

  function automatic longint sub_of(longint t, longint r);
    longint off = (r + 1) * 65536;
    return r - ((t + off) % (r + 1));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // One clock: check current outputs, drive inputs, advance the model one edge.
  task automatic cyc(input bit ps, input bit wr, input longint sh, input bit a1,
                     input string tag);
    longint t_old;
    bit     p_old, d2_old;
    chk({tag, " sec"}, sec_cnt, sec_of(T, R));
    chk({tag, " sub"}, sub_cnt, sub_of(T, R));
    chk("R4/R6 pending", shift_pending, m_pend);
    chk("R10 sync_ok", sync_ok, m_sync);
    chk("R9 shadow_sec", shadow_sec, m_shsec);
    chk("R9 shadow_sub", shadow_sub, m_shsub);
    chk("R3 rdata", shift_rdata, 0);
    ps_en = ps; wr_en = wr; wr_shift = PS_W'(sh); wr_add1s = a1;
    t_old = T; p_old = m_pend; d2_old = d2;
    if (ps) begin
      if (p_old) begin
        T = T + (m_a1 ? R + 1 : 0) - m_sh;
        m_pend = 0;
      end
      T = T + 1;
    end
    if (wr && !p_old) begin
      m_pend = 1; m_sh = sh; m_a1 = a1;
    end
    if (d2_old) begin
      m_shsec = sec_of(t_old, R);
      m_shsub = sub_of(t_old, R);
    end
    if (wr && !p_old)            m_sync = 0;
    else if (d2_old && !p_old)   m_sync = 1;
    d2 = d1; d1 = ps;
    @(negedge clk);
  endtask

  task automatic do_reset(input longint r);
    R = r; reload = PS_W'(r);
    rst_n = 0; ps_en = 0; wr_en = 0; wr_shift = '0; wr_add1s = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    T = 0; m_pend = 0; m_a1 = 0; m_sh = 0; m_sync = 0; d1 = 0; d2 = 0;
    m_shsec = 0; m_shsub = 0;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      bit ps = ($urandom_range(1, 0) == 1);
      bit wr = ($urandom_range(9, 0) == 0);
      cyc(ps, wr, $urandom_range(int'(R), 0), $urandom_range(1, 0) == 1, "R2/R6");
    end
  endtask

  initial begin
    void'($urandom(32'd4321));
    @(negedge clk);
    do_reset(99);
    cyc(0, 0, 0, 0, "R1");                 // reset state
    for (int i = 0; i < 95; i++) cyc(1, 0, 0, 0, "R2");
    // prescaler now at 4; shift by reload crosses a second boundary
    cyc(0, 1, 99, 0, "R4");
    cyc(0, 1, 10, 1, "R5");                // ignored: pending
    cyc(1, 1, 20, 1, "R5");                // ignored even at apply edge
    cyc(0, 0, 0, 0, "R7");                 // wrap result observed here
    cyc(1, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, "R10");
    // add-one-second with zero shift
    cyc(1, 1, 0, 1, "R8");                 // write on a tick edge: not applied yet
    cyc(1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, "R8");
    // shift right at underflow
    for (int i = 0; i < 200; i++) cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 37, 1, "R6");
    cyc(1, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, "R6");
    rand_run(3000);
    do_reset(7);
    cyc(0, 0, 0, 0, "R1");
    cyc(0, 1, 7, 1, "R7");
    cyc(1, 0, 0, 0, "R7");
    rand_run(2000);
    cyc(0, 0, 0, 0, "R2");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule